// File: doc/BRIEF.md
# SCSI Target Command and Phase Mismatch Detector

This block holds the CPU-written target command word: the three information transfer phase bits (input/output, control/data, message) and a request-assert bit. The same word serves two roles. When the controller acts as a bus target, the stored phase bits and the request bit become the drive enables for the matching bus lines. When it acts as an initiator with DMA enabled, the stored phase is compared against the synchronized bus phase lines, and a sticky phase mismatch interrupt is raised when the request line goes active while the two differ.

The block also reports the stored phase as a 3-bit code, flags the two reserved codes, and gives a live match status that the CPU checks before starting an initiator send. Data transfer and the DMA handshake sit elsewhere.

Top module: `scsi_tcmd_phase`

## Requirements
- R1: During and right after reset the stored command word is 0, all four drive enables are 0 and the mismatch interrupt is 0.
- R2: A write stores write-data bit 0 as input/output, bit 1 as control/data, bit 2 as message and bit 3 as request-assert; the read data returns these bits in the same positions from the cycle after the write, and read bits 7 to 4 are always 0 whatever was written there.
- R3: With target mode 1 each of the input/output, control/data, message and request drive enables equals its stored bit; with target mode 0 all four drive enables are 0, so the request-assert bit has no effect on any output in initiator mode.
- R4: The phase code output is {input/output, control/data, message} of the stored word (bit 2 is input/output): 000 data out, 001 reserved, 010 command, 011 message out, 100 data in, 101 reserved, 110 status, 111 message in.
- R5: The reserved flag is 1 exactly when the phase code is 001 or 101.
- R6: The match status is 1 exactly when the bus input/output, control/data and message lines all equal the stored phase bits, combinationally in the same cycle.
- R7: With target mode 0 and DMA mode 1, a clock edge at which the request line is 1, was 0 at the previous edge, and the bus phase differs from the stored phase sets the mismatch interrupt, visible from the following cycle.
- R8: No interrupt is set when the phases match, when DMA mode is 0, when target mode is 1, or while request stays high without a new low-to-high edge.
- R9: Once set, the interrupt stays 1 until a clear strobe; a clear strobe in the same cycle as a new set condition leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | CPU write strobe for the command word |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Command word read data |
| target_mode_i | input | 1 | 1 for target role, 0 for initiator role |
| dma_mode_i | input | 1 | DMA mode enable |
| bus_io_i | input | 1 | Synchronized bus input/output line, active high |
| bus_cd_i | input | 1 | Synchronized bus control/data line, active high |
| bus_msg_i | input | 1 | Synchronized bus message line, active high |
| bus_req_i | input | 1 | Synchronized bus request line, active high |
| irq_clr_i | input | 1 | Clear strobe for the mismatch interrupt |
| drv_io_o | output | 1 | Drive enable for input/output line |
| drv_cd_o | output | 1 | Drive enable for control/data line |
| drv_msg_o | output | 1 | Drive enable for message line |
| drv_req_o | output | 1 | Drive enable for request line |
| phase_code_o | output | 3 | Stored phase code {io, cd, msg} |
| phase_rsvd_o | output | 1 | Stored phase code is reserved |
| phase_match_o | output | 1 | Bus phase equals stored phase |
| mismatch_irq_o | output | 1 | Sticky phase mismatch interrupt |

## Verification
The hardest case to reach is the exact cycle where a fresh request edge with a differing phase coincides with a clear strobe, together with a request line that is held high across a phase change so that no edge occurs. The stimulus gets there by first setting the interrupt, then lowering and raising request in a single cycle while the clear strobe is pulsed, and separately by raising request with matching phase, changing the bus phase while it stays high, and showing the interrupt stays low. The reference model evaluates every output on every clock, so each gated case (DMA off, target role, matching phase) is compared at its own edge.

// File: rtl/tcmd_pkg.sv
package tcmd_pkg;
    localparam int CMD_W   = 8;
    localparam int STORE_W = 4;
    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_DATA_OUT = 3'b000,
        PH_RSVD_A   = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_MSG_OUT  = 3'b011,
        PH_DATA_IN  = 3'b100,
        PH_RSVD_B   = 3'b101,
        PH_STATUS   = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_e;

    typedef struct packed {
        logic req;
        logic msg;
        logic cd;
        logic io;
    } tcmd_t;

    typedef struct packed {
        logic req_prev;
        logic irq;
    } mm_state_t;
endpackage

// File: rtl/tcmd_reg.sv
module tcmd_reg
    import tcmd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CMD_W-1:0] wr_data_i,
    output tcmd_t            cmd_o,
    output logic [CMD_W-1:0] rd_data_o
);
    localparam int PAD_W = CMD_W - STORE_W;

    tcmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (wr_en_i) begin
            cmd_d = tcmd_t'(wr_data_i[STORE_W-1:0]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cmd_q <= '0;
        else         cmd_q <= cmd_d;
    end

    assign cmd_o     = cmd_q;
    assign rd_data_o = {{PAD_W{1'b0}}, cmd_q};

    // R2: a write shows up on the read port one cycle later
    assert_write_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o[STORE_W-1:0] == $past(wr_data_i[STORE_W-1:0])));

    // R2: without a write the stored word holds
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && $past(rst_ni)) |=> $stable(rd_data_o));
endmodule

// File: rtl/tcmd_phase.sv
module tcmd_phase
    import tcmd_pkg::*;
(
    input  tcmd_t              cmd_i,
    input  logic               target_mode_i,
    input  logic               bus_io_i,
    input  logic               bus_cd_i,
    input  logic               bus_msg_i,
    output logic               drv_io_o,
    output logic               drv_cd_o,
    output logic               drv_msg_o,
    output logic               drv_req_o,
    output phase_e             phase_o,
    output logic               rsvd_o,
    output logic               match_o
);
    logic [STORE_W-1:0] bits;
    logic [STORE_W-1:0] drv;
    logic [PHASE_W-1:0] bus_code;

    assign bits = {cmd_i.req, cmd_i.msg, cmd_i.cd, cmd_i.io};

    genvar gi;
    generate
        for (gi = 0; gi < STORE_W; gi++) begin : g_drv
            assign drv[gi] = target_mode_i & bits[gi];
        end
    endgenerate

    assign drv_io_o  = drv[0];
    assign drv_cd_o  = drv[1];
    assign drv_msg_o = drv[2];
    assign drv_req_o = drv[3];

    always_comb begin
        phase_o  = phase_e'({cmd_i.io, cmd_i.cd, cmd_i.msg});
        bus_code = {bus_io_i, bus_cd_i, bus_msg_i};
        rsvd_o   = (phase_o == PH_RSVD_A) || (phase_o == PH_RSVD_B);
        match_o  = (bus_code == phase_o);
    end
endmodule

// File: rtl/tcmd_mismatch.sv
module tcmd_mismatch
    import tcmd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic target_mode_i,
    input  logic dma_mode_i,
    input  logic bus_req_i,
    input  logic match_i,
    input  logic irq_clr_i,
    output logic irq_o
);
    mm_state_t st_d, st_q;
    logic      req_rise;
    logic      set_irq;

    always_comb begin
        req_rise      = bus_req_i & ~st_q.req_prev;
        set_irq       = ~target_mode_i & dma_mode_i & req_rise & ~match_i;
        st_d          = st_q;
        st_d.req_prev = bus_req_i;
        if (set_irq)        st_d.irq = 1'b1;
        else if (irq_clr_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R7: qualifying request edge with differing phase sets the interrupt
    assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!target_mode_i && dma_mode_i && bus_req_i && !match_i && $past(rst_ni) && !$past(bus_req_i))
        |=> irq_o);

    // R9: interrupt holds until a clear strobe
    assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R8: interrupt never sets while the phases match
    assert_no_set_on_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && match_i) |=> !irq_o);

    // R8: interrupt never sets in the target role or with DMA off
    assert_no_set_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && (target_mode_i || !dma_mode_i)) |=> !irq_o);
endmodule

// File: rtl/scsi_tcmd_phase.sv
module scsi_tcmd_phase
    import tcmd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CMD_W-1:0] wr_data_i,
    output logic [CMD_W-1:0] rd_data_o,
    input  logic             target_mode_i,
    input  logic             dma_mode_i,
    input  logic             bus_io_i,
    input  logic             bus_cd_i,
    input  logic             bus_msg_i,
    input  logic             bus_req_i,
    input  logic             irq_clr_i,
    output logic             drv_io_o,
    output logic             drv_cd_o,
    output logic             drv_msg_o,
    output logic             drv_req_o,
    output logic [PHASE_W-1:0] phase_code_o,
    output logic             phase_rsvd_o,
    output logic             phase_match_o,
    output logic             mismatch_irq_o
);
    tcmd_t  cmd;
    phase_e phase;
    logic   match;

    tcmd_reg u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd),
        .rd_data_o (rd_data_o)
    );

    tcmd_phase u_phase (
        .cmd_i         (cmd),
        .target_mode_i (target_mode_i),
        .bus_io_i      (bus_io_i),
        .bus_cd_i      (bus_cd_i),
        .bus_msg_i     (bus_msg_i),
        .drv_io_o      (drv_io_o),
        .drv_cd_o      (drv_cd_o),
        .drv_msg_o     (drv_msg_o),
        .drv_req_o     (drv_req_o),
        .phase_o       (phase),
        .rsvd_o        (phase_rsvd_o),
        .match_o       (match)
    );

    tcmd_mismatch u_mm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .target_mode_i (target_mode_i),
        .dma_mode_i    (dma_mode_i),
        .bus_req_i     (bus_req_i),
        .match_i       (match),
        .irq_clr_i     (irq_clr_i),
        .irq_o         (mismatch_irq_o)
    );

    assign phase_code_o  = phase;
    assign phase_match_o = match;

    // R3: initiator role drives nothing onto the bus
    assert_init_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !target_mode_i |-> !(drv_io_o || drv_cd_o || drv_msg_o || drv_req_o));

    // R5: reserved flag only for codes with control/data low and message high
    assert_rsvd_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_rsvd_o |-> (phase_code_o[1:0] == 2'b01));

    // R2: upper read bits never set
    assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[CMD_W-1:STORE_W] == '0);
endmodule

// File: tb/scsi_tcmd_phase_tb.sv
`timescale 1ns/1ps
module scsi_tcmd_phase_tb_top;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tm = 1'b0, dma = 1'b0;
    logic       bio = 1'b0, bcd = 1'b0, bmsg = 1'b0, breq = 1'b0;
    logic       clr = 1'b0;
    logic       d_io, d_cd, d_msg, d_req;
    logic [2:0] code;
    logic       rsvd, match, irq;

    always #2 clk = ~clk;

    scsi_tcmd_phase dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .target_mode_i(tm), .dma_mode_i(dma),
        .bus_io_i(bio), .bus_cd_i(bcd), .bus_msg_i(bmsg), .bus_req_i(breq),
        .irq_clr_i(clr), .drv_io_o(d_io), .drv_cd_o(d_cd), .drv_msg_o(d_msg),
        .drv_req_o(d_req), .phase_code_o(code), .phase_rsvd_o(rsvd),
        .phase_match_o(match), .mismatch_irq_o(irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string irq_tag = "R8";

    // reference model state
    int m_reg  = 0;
    int m_reqq = 0;
    int m_irq  = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // compare all outputs now, then advance one clock and update the model
    task automatic cyc();
        int io, cd, ms, rq, e_code, b_code, e_match, setc;
        string t1, t2, t3, t4, t5, t6;
        io = m_reg & 1; cd = (m_reg >> 1) & 1; ms = (m_reg >> 2) & 1; rq = (m_reg >> 3) & 1;
        e_code  = io * 4 + cd * 2 + ms;
        b_code  = int'(bio) * 4 + int'(bcd) * 2 + int'(bmsg);
        e_match = (b_code == e_code) ? 1 : 0;
        if (!rst_ni) begin
            t1 = "R1"; t2 = "R1"; t3 = "R1"; t4 = "R1"; t5 = "R1"; t6 = "R1";
        end else begin
            t1 = "R2"; t2 = "R3"; t3 = "R4"; t4 = "R5"; t5 = "R6"; t6 = irq_tag;
        end
        #1;
        chk(t1, "rd_data", int'(rd_data), m_reg);
        chk(t2, "drv_io",  int'(d_io),  tm ? io : 0);
        chk(t2, "drv_cd",  int'(d_cd),  tm ? cd : 0);
        chk(t2, "drv_msg", int'(d_msg), tm ? ms : 0);
        chk(t2, "drv_req", int'(d_req), tm ? rq : 0);
        chk(t3, "phase_code", int'(code), e_code);
        chk(t4, "rsvd", int'(rsvd), (e_code == 1 || e_code == 5) ? 1 : 0);
        chk(t5, "match", int'(match), e_match);
        chk(t6, "irq", int'(irq), m_irq);
        setc = (!tm && dma && breq && m_reqq == 0 && e_match == 0) ? 1 : 0;
        @(posedge clk);
        if (!rst_ni) begin
            m_reg = 0; m_reqq = 0; m_irq = 0;
        end else begin
            if (setc == 1)  m_irq = 1;
            else if (clr)   m_irq = 0;
            m_reqq = int'(breq);
            if (wr_en) m_reg = int'(wr_data) & 15;
        end
        @(negedge clk);
    endtask

    task automatic wr(input int v);
        wr_en = 1'b1; wr_data = 8'(v); cyc(); wr_en = 1'b0;
    endtask

    task automatic bus(input int ph);
        bio = ph[2]; bcd = ph[1]; bmsg = ph[0];
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        breq = 1'b1; wr_en = 1'b1; wr_data = 8'hFF; tm = 1'b1;
        // R1: reset state while inputs are active
        for (int i = 0; i < 3; i++) cyc();
        wr_en = 1'b0; breq = 1'b0; tm = 1'b0;
        rst_ni = 1'b1;
        cyc();

        // R2: readback, upper bits dropped
        wr(8'hF5); cyc();
        wr(8'h0A); cyc();
        wr(8'h70); cyc();

        // R3, R4, R5: every value in both roles
        for (int v = 0; v < 16; v++) begin
            wr(v);
            tm = 1'b1; cyc();
            tm = 1'b0; cyc();
        end

        // R6: match across all bus phases against a few stored phases
        for (int s = 0; s < 8; s += 3) begin
            wr(s[0] * 1 + s[1] * 2 + s[2] * 4 + 8);
            for (int p = 0; p < 8; p++) begin bus(p); cyc(); end
        end

        // R7: mismatch edge in initiator DMA mode (stored status = io,cd -> 4'b0011)
        irq_tag = "R7";
        wr(4'b0011); tm = 1'b0; dma = 1'b1; bus(3'b100);
        breq = 1'b1; cyc(); cyc();
        // R9: sticky across request low and phase change
        irq_tag = "R9";
        breq = 1'b0; bus(3'b110); cyc(); cyc();
        clr = 1'b1; cyc(); clr = 1'b0; cyc();

        // R8: matching phase on edge
        irq_tag = "R8";
        bus(3'b110); breq = 1'b1; cyc();
        // R8: request held high while phase changes
        bus(3'b000); cyc(); cyc(); breq = 1'b0; cyc();
        // R8: DMA off
        dma = 1'b0; breq = 1'b1; cyc(); cyc(); breq = 1'b0; cyc();
        // R8: target role
        dma = 1'b1; tm = 1'b1; breq = 1'b1; cyc(); cyc(); breq = 1'b0; tm = 1'b0; cyc();

        // R9: set and clear in the same cycle, set wins
        irq_tag = "R9";
        breq = 1'b1; cyc(); cyc();
        breq = 1'b0; cyc();
        breq = 1'b1; clr = 1'b1; cyc(); clr = 1'b0; cyc();
        clr = 1'b1; cyc(); clr = 1'b0; cyc();

        // R7: edge right after a write changing the stored phase
        irq_tag = "R7";
        breq = 1'b0; cyc();
        wr(4'b0000); bus(3'b001); breq = 1'b1; cyc(); cyc();
        breq = 1'b0; clr = 1'b1; cyc(); clr = 1'b0; cyc();

        finish_run();
    end
endmodule